// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic core of a small RISC processor together with its status register. Each cycle the surrounding pipeline may issue one operation: a code on `op_sel`, two byte operands and, for the word operations, a 16-bit register pair. One clock edge later the block presents the result and a write-enable for the destination. It also presents the updated status register and a mask of the flag bits that this operation was allowed to change. Operations that carry a constant (add, subtract, subtract with carry, compare) reuse the register form with the constant placed on `opnd_b`.

Every operation has its own set of affected flags. Logic operations, increment and decrement never touch carry. The nibble swap touches no flag at all. Compare variants set flags without writing a result. Subtract-with-carry and compare-with-carry can only clear the zero flag, never set it, so that a compare over several bytes can be chained one byte at a time. A flag-test port compares any one status bit against a wanted level, so a branch or skip unit can decide with no logic of its own. Testing the sign bit against 0 gives signed greater-or-equal.

Top module: `alu8_flags`

## Requirements
- R1: While `rst_n` is low and after its release, `flags_q`, `res_q`, `res_we_q` and `upd_mask_q` are all zero until an operation is issued.
- R2: Status bit positions: 7 = interrupt enable, 6 = bit store, 5 = half carry H, 4 = sign S, 3 = overflow V, 2 = negative N, 1 = zero Z, 0 = carry C. Operation codes on `op_sel`: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 compare, 5 compare with carry, 6 negate, 7 and, 8 or, 9 exclusive or, 10 one's complement, 11 increment, 12 decrement, 13 shift left, 14 logical shift right, 15 rotate left through carry, 16 rotate right through carry, 17 arithmetic shift right, 18 nibble swap, 19 word add, 20 word subtract, 21 set flag, 22 clear flag, 23 no operation. Byte results appear in `res_q[7:0]` with `res_q[15:8]` zero.
- R3: An operation sampled with `op_valid` high at a rising edge is reflected in all registered outputs after that same edge. A cycle with `op_valid` low leaves `flags_q` and `res_q` unchanged and drives `res_we_q` and `upd_mask_q` to zero.
- R4: Add, add with carry, subtract and negate (0 minus A) write the 8-bit result and update H, S, V, N, Z and C (mask 0x3F). C is the carry or borrow out of bit 7, H the carry or borrow at bit 3, and V the two's-complement overflow. Only the with-carry forms consume the old C.
- R5: Compare and compare with carry update flags exactly as the matching subtract but leave `res_we_q` low and `res_q` unchanged.
- R6: For subtract with carry and compare with carry, Z becomes 1 only when the result is zero and Z was already 1. Otherwise Z becomes 0.
- R7: And, or, exclusive or, increment and decrement update only S, V, N and Z (mask 0x1E) and keep C and H. V is 0 for the logic operations, set by increment only from 0x7F, and set by decrement only from 0x80.
- R8: One's complement writes 0xFF minus A, sets C to 1, clears V, and updates S, V, N, Z and C (mask 0x1F).
- R9: The five shifts update S, V, N, Z and C (mask 0x1F) and keep H. C takes the bit shifted out and V = N xor C. Shift left and logical right fill with 0. Rotates fill with the old C (into bit 0 going left, into bit 7 going right). Arithmetic right keeps bit 7.
- R10: Nibble swap writes A with its two 4-bit halves exchanged and changes no flag (mask 0).
- R11: Word add and word subtract compute `pair_in` plus or minus the zero-extended `opnd_b` on 16 bits and write all 16 result bits. C is the carry or borrow out of bit 15 and V the 16-bit signed overflow. N is bit 15 and Z is a zero test over all 16 bits. S, V, N, Z and C update (mask 0x1F) and H is kept.
- R12: Whenever an operation updates both N and S, the new S equals new N xor new V.
- R13: Set flag and clear flag force the single status bit indexed by `opnd_b[2:0]` to 1 or 0. All other bits are kept, the mask is that one bit, and no result is written.
- R14: `cond_hit` is 1 exactly when status bit `tst_sel` of the current `flags_q` equals `tst_want`, in the same cycle and without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue the operation on `op_sel` this cycle |
| op_sel | input | 5 | Operation code |
| opnd_a | input | 8 | First byte operand (destination value) |
| opnd_b | input | 8 | Second byte operand, constant, or flag index |
| pair_in | input | 16 | Register pair for word operations |
| tst_sel | input | 3 | Status bit to test |
| tst_want | input | 1 | Level the tested bit must have |
| res_q | output | 16 | Last written result |
| res_we_q | output | 1 | Result must be written back this cycle |
| flags_q | output | 8 | Status register |
| upd_mask_q | output | 8 | Flag bits the last operation was allowed to change |
| cond_hit | output | 1 | Tested bit equals wanted level |

## Verification
Result, write-enable, status and mask all come from one register stage. They are due one rising edge after the cycle that issued the operation. The bench drives each operation on a falling edge and, on the next falling edge, compares all four outputs with a behavioural model advanced by exactly one step. `cond_hit` has no register of its own: the bench checks it on that same falling edge against the model's status value and the test inputs driven half a cycle earlier. Only then does it drive the next stimulus, so an idle cycle is checked against held values before anything else can move them.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int ALU_DW     = 8;
    localparam int FLAG_W     = 8;
    localparam int FLAG_SEL_W = $clog2(FLAG_W);

    // status bit positions (decoded by branch logic, kept fixed)
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;

    localparam logic [FLAG_W-1:0] UPD_NONE   = 8'h00;
    localparam logic [FLAG_W-1:0] UPD_SVNZ   = 8'h1E;
    localparam logic [FLAG_W-1:0] UPD_SVNZC  = 8'h1F;
    localparam logic [FLAG_W-1:0] UPD_HSVNZC = 8'h3F;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
        OP_CP   = 5'd4,  OP_CPC  = 5'd5,  OP_NEG  = 5'd6,  OP_AND  = 5'd7,
        OP_OR   = 5'd8,  OP_EOR  = 5'd9,  OP_COM  = 5'd10, OP_INC  = 5'd11,
        OP_DEC  = 5'd12, OP_LSL  = 5'd13, OP_LSR  = 5'd14, OP_ROL  = 5'd15,
        OP_ROR  = 5'd16, OP_ASR  = 5'd17, OP_SWAP = 5'd18, OP_WADD = 5'd19,
        OP_WSUB = 5'd20, OP_FSET = 5'd21, OP_FCLR = 5'd22, OP_NOP  = 5'd23
    } alu_op_e;

    typedef struct packed {
        logic h;
        logic v;
        logic n;
        logic z;
        logic c;
    } flag_cand_t;

    // candidate flags laid out at their status positions, sign derived
    function automatic logic [FLAG_W-1:0] cand_to_vec(flag_cand_t f);
        logic [FLAG_W-1:0] vec;
        vec       = '0;
        vec[FL_C] = f.c;
        vec[FL_Z] = f.z;
        vec[FL_N] = f.n;
        vec[FL_V] = f.v;
        vec[FL_S] = f.n ^ f.v;
        vec[FL_H] = f.h;
        return vec;
    endfunction

endpackage

// File: rtl/alu8_byte_unit.sv
module alu8_byte_unit
    import alu8_pkg::*;
#(
    parameter int DATA_W = ALU_DW
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic                c_in,
    input  logic                h_in,
    input  logic                z_in,
    output logic [DATA_W-1:0]   res,
    output flag_cand_t          cand,
    output logic [FLAG_W-1:0]   upd,
    output logic                wr
);

    localparam int NIB = DATA_W / 2;
    localparam int MSB = DATA_W - 1;

    logic              add_ci;
    logic              sub_ci;
    logic              is_neg;
    logic              chain_z;
    logic              shift_v;
    logic [DATA_W-1:0] sub_x;
    logic [DATA_W-1:0] sub_y;
    logic [DATA_W:0]   add_full;
    logic [DATA_W:0]   sub_full;
    logic [NIB:0]      add_nib;
    logic [NIB:0]      sub_nib;

    always_comb begin
        is_neg  = (op == OP_NEG);
        add_ci  = (op == OP_ADC) && c_in;
        sub_ci  = ((op == OP_SBC) || (op == OP_CPC)) && c_in;
        chain_z = (op == OP_SBC) || (op == OP_CPC);
        sub_x   = is_neg ? '0 : a;
        sub_y   = is_neg ? a : b;

        add_full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, add_ci};
        add_nib  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, add_ci};
        sub_full = {1'b0, sub_x} - {1'b0, sub_y} - {{DATA_W{1'b0}}, sub_ci};
        sub_nib  = {1'b0, sub_x[NIB-1:0]} - {1'b0, sub_y[NIB-1:0]} - {{NIB{1'b0}}, sub_ci};

        res     = a;
        cand.c  = c_in;
        cand.h  = h_in;
        cand.v  = 1'b0;
        cand.n  = 1'b0;
        cand.z  = 1'b0;
        upd     = UPD_NONE;
        wr      = 1'b0;
        shift_v = 1'b0;

        case (op)
            OP_ADD, OP_ADC: begin
                res    = add_full[MSB:0];
                cand.c = add_full[DATA_W];
                cand.h = add_nib[NIB];
                cand.v = (a[MSB] == b[MSB]) && (add_full[MSB] != a[MSB]);
                upd    = UPD_HSVNZC;
                wr     = 1'b1;
            end
            OP_SUB, OP_SBC, OP_NEG, OP_CP, OP_CPC: begin
                res    = sub_full[MSB:0];
                cand.c = sub_full[DATA_W];
                cand.h = sub_nib[NIB];
                cand.v = (sub_x[MSB] != sub_y[MSB]) && (sub_full[MSB] != sub_x[MSB]);
                upd    = UPD_HSVNZC;
                wr     = (op != OP_CP) && (op != OP_CPC);
            end
            OP_AND: begin res = a & b; upd = UPD_SVNZ; wr = 1'b1; end
            OP_OR:  begin res = a | b; upd = UPD_SVNZ; wr = 1'b1; end
            OP_EOR: begin res = a ^ b; upd = UPD_SVNZ; wr = 1'b1; end
            OP_COM: begin
                res    = ~a;
                cand.c = 1'b1;
                upd    = UPD_SVNZC;
                wr     = 1'b1;
            end
            OP_INC: begin
                res    = a + DATA_W'(1);
                cand.v = (a == {1'b0, {MSB{1'b1}}});
                upd    = UPD_SVNZ;
                wr     = 1'b1;
            end
            OP_DEC: begin
                res    = a - DATA_W'(1);
                cand.v = (a == {1'b1, {MSB{1'b0}}});
                upd    = UPD_SVNZ;
                wr     = 1'b1;
            end
            OP_LSL: begin res = {a[MSB-1:0], 1'b0};  cand.c = a[MSB]; shift_v = 1'b1; end
            OP_LSR: begin res = {1'b0, a[MSB:1]};    cand.c = a[0];   shift_v = 1'b1; end
            OP_ROL: begin res = {a[MSB-1:0], c_in};  cand.c = a[MSB]; shift_v = 1'b1; end
            OP_ROR: begin res = {c_in, a[MSB:1]};    cand.c = a[0];   shift_v = 1'b1; end
            OP_ASR: begin res = {a[MSB], a[MSB:1]};  cand.c = a[0];   shift_v = 1'b1; end
            OP_SWAP: begin
                res = {a[NIB-1:0], a[MSB:NIB]};
                wr  = 1'b1;
            end
            default: begin
                res = a;
            end
        endcase

        cand.n = res[MSB];
        cand.z = (res == '0) && (!chain_z || z_in);
        if (shift_v) begin
            cand.v = res[MSB] ^ cand.c;
            upd    = UPD_SVNZC;
            wr     = 1'b1;
        end
    end

endmodule

// File: rtl/alu8_word_unit.sv
module alu8_word_unit
    import alu8_pkg::*;
#(
    parameter int DATA_W = ALU_DW
) (
    input  logic                  sub_mode,
    input  logic [2*DATA_W-1:0]   pair,
    input  logic [DATA_W-1:0]     imm,
    output logic [2*DATA_W-1:0]   res,
    output flag_cand_t            cand
);

    localparam int WORD_W = 2 * DATA_W;
    localparam int WMSB   = WORD_W - 1;

    logic [WORD_W-1:0] k_ext;
    logic [WORD_W:0]   full;

    always_comb begin
        k_ext = {{DATA_W{1'b0}}, imm};
        if (sub_mode) begin
            full   = {1'b0, pair} - {1'b0, k_ext};
            cand.v = (pair[WMSB] != k_ext[WMSB]) && (full[WMSB] != pair[WMSB]);
        end else begin
            full   = {1'b0, pair} + {1'b0, k_ext};
            cand.v = (pair[WMSB] == k_ext[WMSB]) && (full[WMSB] != pair[WMSB]);
        end
        res    = full[WMSB:0];
        cand.c = full[WORD_W];
        cand.n = full[WMSB];
        cand.z = (full[WMSB:0] == '0);
        cand.h = 1'b0;
    end

endmodule

// File: rtl/alu8_flag_test.sv
module alu8_flag_test
    import alu8_pkg::*;
(
    input  logic [FLAG_W-1:0]     flags,
    input  logic [FLAG_SEL_W-1:0] sel,
    input  logic                  want,
    output logic                  hit
);

    always_comb begin
        hit = (flags[sel] == want);
    end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int DATA_W = ALU_DW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic [4:0]             op_sel,
    input  logic [DATA_W-1:0]      opnd_a,
    input  logic [DATA_W-1:0]      opnd_b,
    input  logic [2*DATA_W-1:0]    pair_in,
    input  logic [FLAG_SEL_W-1:0]  tst_sel,
    input  logic                   tst_want,
    output logic [2*DATA_W-1:0]    res_q,
    output logic                   res_we_q,
    output logic [FLAG_W-1:0]      flags_q,
    output logic [FLAG_W-1:0]      upd_mask_q,
    output logic                   cond_hit
);

    localparam int WORD_W = 2 * DATA_W;

    typedef struct packed {
        logic [WORD_W-1:0] res;
        logic              we;
        logic [FLAG_W-1:0] flags;
        logic [FLAG_W-1:0] upd;
    } alu_state_t;

    alu_state_t st_d;
    alu_state_t st_q;

    alu_op_e           op;
    logic [DATA_W-1:0] b_res;
    flag_cand_t        b_cand;
    logic [FLAG_W-1:0] b_upd;
    logic              b_wr;
    logic [WORD_W-1:0] w_res;
    flag_cand_t        w_cand;
    logic [FLAG_W-1:0] fresh;

    assign op = alu_op_e'(op_sel);

    alu8_byte_unit #(.DATA_W(DATA_W)) i_byte (
        .op       (op),
        .a        (opnd_a),
        .b        (opnd_b),
        .c_in     (st_q.flags[FL_C]),
        .h_in     (st_q.flags[FL_H]),
        .z_in     (st_q.flags[FL_Z]),
        .res      (b_res),
        .cand     (b_cand),
        .upd      (b_upd),
        .wr       (b_wr)
    );

    alu8_word_unit #(.DATA_W(DATA_W)) i_word (
        .sub_mode (op == OP_WSUB),
        .pair     (pair_in),
        .imm      (opnd_b),
        .res      (w_res),
        .cand     (w_cand)
    );

    alu8_flag_test i_test (
        .flags    (st_q.flags),
        .sel      (tst_sel),
        .want     (tst_want),
        .hit      (cond_hit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.we  = 1'b0;
        st_d.upd = UPD_NONE;
        fresh    = '0;
        if (op_valid) begin
            case (op)
                OP_WADD, OP_WSUB: begin
                    st_d.res = w_res;
                    st_d.we  = 1'b1;
                    st_d.upd = UPD_SVNZC;
                    fresh    = cand_to_vec(w_cand);
                end
                OP_FSET, OP_FCLR: begin
                    st_d.upd = FLAG_W'(1) << opnd_b[FLAG_SEL_W-1:0];
                    fresh    = {FLAG_W{op == OP_FSET}};
                end
                OP_NOP: begin
                    st_d.upd = UPD_NONE;
                end
                default: begin
                    if (b_wr) begin
                        st_d.res = {{DATA_W{1'b0}}, b_res};
                    end
                    st_d.we  = b_wr;
                    st_d.upd = b_upd;
                    fresh    = cand_to_vec(b_cand);
                end
            endcase
        end
        st_d.flags = (st_q.flags & ~st_d.upd) | (fresh & st_d.upd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_q      = st_q.res;
    assign res_we_q   = st_q.we;
    assign flags_q    = st_q.flags;
    assign upd_mask_q = st_q.upd;

endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
    import alu8_pkg::*;
#(
    parameter int DATA_W = ALU_DW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [4:0]            op_sel,
    input  logic [2*DATA_W-1:0]   res_q,
    input  logic                  res_we_q,
    input  logic [FLAG_W-1:0]     flags_q,
    input  logic [FLAG_W-1:0]     upd_mask_q
);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_we_q && (upd_mask_q == '0)
                       && (flags_q == $past(flags_q)) && (res_q == $past(res_q))));

    // R10
    untouched_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (((flags_q ^ $past(flags_q)) & ~upd_mask_q) == '0));

    // R12
    sign_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_mask_q[FL_S] && upd_mask_q[FL_N])
            |-> (flags_q[FL_S] == (flags_q[FL_N] ^ flags_q[FL_V])));

    // R5
    compare_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ((op_sel == OP_CP) || (op_sel == OP_CPC)))
            |=> (!res_we_q && (res_q == $past(res_q))));

    // R6
    zero_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ((op_sel == OP_SBC) || (op_sel == OP_CPC)) && !flags_q[FL_Z])
            |=> !flags_q[FL_Z]);

    // R13
    single_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ((op_sel == OP_FSET) || (op_sel == OP_FCLR)))
            |=> (($countones(upd_mask_q) == 1) && !res_we_q));

endmodule

bind alu8_flags alu8_flags_chk #(.DATA_W(DATA_W)) i_alu8_flags_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_sel     (op_sel),
    .res_q      (res_q),
    .res_we_q   (res_we_q),
    .flags_q    (flags_q),
    .upd_mask_q (upd_mask_q)
);

// File: tb/test_alu8_flags.sv
`timescale 1ns/1ps
module test_alu8_flags;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_sel = '0;
    logic [7:0]  opnd_a = '0;
    logic [7:0]  opnd_b = '0;
    logic [15:0] pair_in = '0;
    logic [2:0]  tst_sel = '0;
    logic        tst_want = 1'b0;
    logic [15:0] res_q;
    logic        res_we_q;
    logic [7:0]  flags_q;
    logic [7:0]  upd_mask_q;
    logic        cond_hit;

    int n_chk = 0;
    int n_err = 0;
    int e_flags = 0;
    int e_res = 0;
    int e_we = 0;
    int e_mask = 0;
    string e_tag = "R1";

    always #2.5 clk = ~clk;

    alu8_flags i_alu8_flags (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .pair_in(pair_in),
        .tst_sel(tst_sel), .tst_want(tst_want), .res_q(res_q),
        .res_we_q(res_we_q), .flags_q(flags_q), .upd_mask_q(upd_mask_q),
        .cond_hit(cond_hit)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(e_tag, "result", int'(res_q), e_res);
        chk(e_tag, "write enable", int'(res_we_q), e_we);
        chk(e_tag, "flags", int'(flags_q), e_flags);
        chk(e_tag, "update mask", int'(upd_mask_q), e_mask);
        chk("R14", "cond_hit", int'(cond_hit), int'(((e_flags >> tst_sel) & 1) == int'(tst_want)));
        if ((e_mask & 8'h14) == 8'h14)
            chk("R12", "sign rule", int'(flags_q[4]), int'(flags_q[2] ^ flags_q[3]));
    endtask

    function automatic int sx8(int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    // behavioural model: advance expected state by one issued cycle
    task automatic model(bit v, int op, int a, int b, int p);
        int r, c, h, vv, n, z, ci, x, y, t, m, we, word, nv;
        if (!v) begin
            e_we = 0; e_mask = 0; e_tag = "R3";
            return;
        end
        r = a; c = e_flags & 1; h = (e_flags >> 5) & 1; vv = 0; m = 0; we = 0; word = 0;
        n = 0; z = 0; nv = 0;
        case (op)
            0, 1: begin
                ci = (op == 1) ? (e_flags & 1) : 0;
                t = a + b + ci; r = t % 256; c = int'(t > 255);
                h = int'((a % 16) + (b % 16) + ci > 15);
                t = sx8(a) + sx8(b) + ci; vv = int'(t > 127 || t < -128);
                m = 8'h3F; we = 1; e_tag = "R4";
            end
            2, 3, 4, 5, 6: begin
                x = (op == 6) ? 0 : a; y = (op == 6) ? a : b;
                ci = (op == 3 || op == 5) ? (e_flags & 1) : 0;
                t = x - y - ci; r = (t + 512) % 256; c = int'(t < 0);
                h = int'((x % 16) - (y % 16) - ci < 0);
                t = sx8(x) - sx8(y) - ci; vv = int'(t > 127 || t < -128);
                m = 8'h3F; we = int'(op != 4 && op != 5);
                e_tag = (op == 3 || op == 5) ? "R6" : ((op == 4) ? "R5" : "R4");
            end
            7:  begin r = a & b; m = 8'h1E; we = 1; e_tag = "R7"; end
            8:  begin r = a | b; m = 8'h1E; we = 1; e_tag = "R7"; end
            9:  begin r = a ^ b; m = 8'h1E; we = 1; e_tag = "R7"; end
            10: begin r = 255 - a; c = 1; m = 8'h1F; we = 1; e_tag = "R8"; end
            11: begin r = (a + 1) % 256; vv = int'(a == 127); m = 8'h1E; we = 1; e_tag = "R7"; end
            12: begin r = (a + 255) % 256; vv = int'(a == 128); m = 8'h1E; we = 1; e_tag = "R7"; end
            13: begin r = (a * 2) % 256; c = a / 128; end
            14: begin r = a / 2; c = a % 2; end
            15: begin r = (a * 2) % 256 + (e_flags & 1); c = a / 128; end
            16: begin r = a / 2 + 128 * (e_flags & 1); c = a % 2; end
            17: begin r = a / 2 + (a / 128) * 128; c = a % 2; end
            18: begin r = (a % 16) * 16 + a / 16; we = 1; e_tag = "R10"; end
            19, 20: begin
                t = (op == 19) ? p + b : p - b;
                r = (t + 65536) % 65536; c = int'(t < 0 || t > 65535);
                x = (p >= 32768) ? p - 65536 : p;
                t = (op == 19) ? x + b : x - b;
                vv = int'(t > 32767 || t < -32768);
                n = r / 32768; z = int'(r == 0);
                m = 8'h1F; we = 1; word = 1; e_tag = "R11";
            end
            21, 22: begin
                m = 1 << (b % 8); nv = (op == 21) ? 255 : 0; e_tag = "R13";
            end
            default: begin e_tag = "R3"; end
        endcase
        if (op >= 13 && op <= 17) begin
            m = 8'h1F; we = 1; e_tag = "R9";
        end
        if (op <= 18 && word == 0) begin
            n = r / 128;
            z = int'(r == 0);
            if (op == 3 || op == 5) z = z & ((e_flags >> 1) & 1);
            if (op >= 13 && op <= 17) vv = n ^ c;
            nv = (h << 5) | ((n ^ vv) << 4) | (vv << 3) | (n << 2) | (z << 1) | c;
        end else if (word == 1) begin
            nv = ((n ^ vv) << 4) | (vv << 3) | (n << 2) | (z << 1) | c;
        end
        e_flags = (e_flags & ~m & 255) | (nv & m);
        e_we = we;
        e_mask = m;
        if (we != 0) e_res = r;
    endtask

    task automatic step(bit v, int op, int a, int b, int p, int ts, int tw);
        @(negedge clk);
        compare_all();
        op_valid = v;
        op_sel   = 5'(op);
        opnd_a   = 8'(a);
        opnd_b   = 8'(b);
        pair_in  = 16'(p);
        tst_sel  = 3'(ts);
        tst_want = tw[0];
        model(v, op, a, b, p);
    endtask

    function automatic int pick8();
        case ($urandom_range(0, 5))
            0: return 0;
            1: return 8'h7F;
            2: return 8'h80;
            3: return 8'hFF;
            default: return int'($urandom_range(0, 255));
        endcase
    endfunction

    initial begin
        #750000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset result", int'(res_q), 0);
        chk("R1", "reset write enable", int'(res_we_q), 0);
        chk("R1", "reset flags", int'(flags_q), 0);
        chk("R1", "reset mask", int'(upd_mask_q), 0);
        rst_n = 1'b1;
        step(0, 23, 0, 0, 0, 0, 0);
        // R4 overflow into sign, half carry
        step(1, 0, 8'h7F, 8'h01, 0, 3, 1);
        // R4 zero with carry
        step(1, 0, 8'hFF, 8'h01, 0, 1, 1);
        // R4 add with carry consumes C
        step(1, 1, 8'h0F, 8'h00, 0, 5, 1);
        // R4 borrow
        step(1, 2, 8'h00, 8'h01, 0, 0, 1);
        // R5 equal compare leaves result
        step(1, 4, 8'h10, 8'h10, 0, 1, 1);
        // R6 multi-byte compare 0x0100 vs 0x00FF
        step(1, 4, 8'h00, 8'hFF, 0, 0, 1);
        step(1, 5, 8'h01, 8'h00, 0, 1, 0);
        step(1, 4, 8'h05, 8'h05, 0, 1, 1);
        step(1, 5, 8'h07, 8'h07, 0, 1, 1);
        step(1, 3, 8'h20, 8'h20, 0, 1, 1);
        // R4 negate
        step(1, 6, 8'h80, 0, 0, 3, 1);
        step(1, 6, 8'h00, 0, 0, 0, 0);
        // R7 increment/decrement keep C
        step(1, 10, 8'h55, 0, 0, 0, 1);
        step(0, 23, 0, 0, 0, 0, 0);
        chk("R2", "carry at bit 0 after complement", int'(flags_q[0]), 1);
        chk("R8", "complement result", int'(res_q), 8'hAA);
        step(1, 11, 8'h7F, 0, 0, 3, 1);
        step(1, 12, 8'h80, 0, 0, 3, 1);
        step(1, 11, 8'hFF, 0, 0, 0, 1);
        step(1, 7, 8'hF0, 8'h0F, 0, 1, 1);
        // R9 shifts
        step(1, 14, 8'h01, 0, 0, 0, 1);
        step(1, 16, 8'h02, 0, 0, 2, 1);
        step(1, 17, 8'h81, 0, 0, 2, 1);
        step(1, 15, 8'h80, 0, 0, 0, 1);
        step(1, 13, 8'h80, 0, 0, 1, 1);
        // R10 swap
        step(1, 18, 8'h3C, 0, 0, 5, 0);
        // R11 word edges
        step(1, 19, 0, 8'h01, 16'hFFFF, 1, 1);
        step(1, 19, 0, 8'h01, 16'h7FFF, 3, 1);
        step(1, 20, 0, 8'h01, 16'h0000, 0, 1);
        step(1, 20, 0, 8'h01, 16'h8000, 4, 1);
        // R13 single flag set/clear
        step(1, 21, 0, 7, 0, 7, 1);
        step(1, 21, 0, 6, 0, 6, 1);
        step(1, 22, 0, 7, 0, 7, 0);
        // R14 signed less-than through sign bit: -128 vs 1
        step(1, 4, 8'h80, 8'h01, 0, 4, 0);
        step(1, 4, 8'h01, 8'h80, 0, 4, 0);
        step(0, 0, 8'h12, 8'h34, 0, 4, 0);
        step(0, 21, 0, 3, 0, 3, 1);
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 9) != 0, int'($urandom_range(0, 23)), pick8(), pick8(),
                 int'($urandom_range(0, 65535)), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 1)));
        end
        step(0, 23, 0, 0, 0, 0, 0);
        step(0, 23, 0, 0, 0, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule